// File: doc/BRIEF.md
# Light Output Timing Protector

This block sits between the activation request of one light channel and the enable of its driver. It guards the light against two stresses: being kept on for too long, and being switched back on too soon after it went off. Each guard has its own enable bit and its own 8-bit limit, counted in milliseconds. A prescaler derives the millisecond tick from the system clock.

If a request stays high past the on-time limit, the drive is forced low and stays low until the request is released. If a request rises before the minimum off-time has passed since the drive last went low, the turn-on is not dropped. It is held back and takes effect as soon as the off-time is met, as long as the request is still present. A chip with four light channels uses four instances.

The drive output is registered and follows the request one clock later, except where a guard intervenes. The request, limits and enables are plain level signals. There is no data stream, so the block has no handshake.

Top module: `light_guard`

## Requirements
- R1: While reset is asserted, `drive_o` is 0. After reset the off-time counts as already met, so a request raised in the first cycle drives the output high one cycle later.
- R2: With both enables at 0, `drive_o` in each cycle equals `req_i` of the previous cycle.
- R3: `drive_o` rises one cycle after `req_i` is sampled high, provided the drive is off and the off-time is met or not enforced. It never rises without a request in the previous cycle.
- R4: When `req_i` is sampled low while the drive is on, `drive_o` is 0 in the next cycle.
- R5: With `on_chk_en_i` = 1 and `req_i` held high, `drive_o` stays high for exactly on_limit × TICK_DIV clock cycles and then goes low.
- R6: After the on-time limit has forced the drive low, it stays low for as long as `req_i` stays high. Once `req_i` has been low, a new request is accepted under the normal rules.
- R7: With `off_chk_en_i` = 1, a request that arrives early is postponed. `drive_o` then rises exactly off_limit × TICK_DIV cycles after its last falling edge, and it is never low for fewer cycles than that between two high periods.
- R8: A postponed turn-on is abandoned if `req_i` goes low before the off-time ends. The drive stays low until a later request arrives.
- R9: A limit value of 0 is treated as 1 ms.
- R10: The off-time is measured from the falling edge of `drive_o`, including a falling edge caused by the on-time limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Activation request for the light |
| on_limit_i | input | LIM_W | Maximum on-time in ms (0 acts as 1) |
| off_limit_i | input | LIM_W | Minimum off-time in ms (0 acts as 1) |
| on_chk_en_i | input | 1 | Enable the on-time cap |
| off_chk_en_i | input | 1 | Enable the minimum off-time |
| drive_o | output | 1 | Light driver enable |

## Verification
The following properties are checked on every cycle:
- the drive never rises without a request in the previous cycle;
- the drive drops one cycle after the request drops;
- no high period outlasts the on-time limit while the limit is enabled and unchanged;
- no low period that ends in a turn-on is shorter than the off-time limit while that limit is enabled and unchanged.

Only the bench scenarios can show:
- the exact cycle at which a postponed turn-on lands;
- that a forced-off drive stays low while the request is held;
- the cancellation of an abandoned early request;
- the treatment of zero limits;
- pass-through behaviour with both guards disabled.

// File: rtl/lg_pkg.sv
package lg_pkg;

  typedef enum logic [1:0] {
    LG_OFF  = 2'd0,
    LG_ON   = 2'd1,
    LG_HOLD = 2'd2
  } lg_state_e;

endpackage

// File: rtl/lg_tick_gen.sv
// Millisecond tick prescaler; restarts its phase on clr_i so that every
// timing window begins on an exact millisecond boundary.
module lg_tick_gen #(
  parameter int unsigned TICK_DIV = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);

  generate
    if (TICK_DIV <= 1) begin : g_passthru
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (clr_i)          cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/lg_window.sv
// Counts millisecond ticks since the last clear and reports when the
// programmed limit is reached. done is sticky until the next clear.
module lg_window #(
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             done_o
);

  logic [LIM_W-1:0] cnt_q;
  logic             done_q;
  logic [LIM_W-1:0] lim_eff;
  logic [LIM_W:0]   cnt_nxt;
  logic             hit;

  assign lim_eff = (limit_i == '0) ? {{(LIM_W-1){1'b0}}, 1'b1} : limit_i;
  assign cnt_nxt = {1'b0, cnt_q} + {{LIM_W{1'b0}}, 1'b1};
  assign hit     = tick_i && !done_q && (cnt_nxt >= {1'b0, lim_eff});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b1;
    end else if (clr_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (tick_i && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
      if (hit)                     done_q <= 1'b1;
    end
  end

  assign done_o = done_q || hit;

endmodule

// File: rtl/lg_ctrl.sv
// Drive state machine: on, off, and forced-off hold after an on-time cap.
module lg_ctrl
  import lg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic on_en_i,
  input  logic off_en_i,
  input  logic win_done_i,
  output logic clr_o,
  output logic drive_o
);

  lg_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      LG_OFF:  if (req_i && (!off_en_i || win_done_i)) st_d = LG_ON;
      LG_ON:   if (!req_i)                             st_d = LG_OFF;
               else if (on_en_i && win_done_i)         st_d = LG_HOLD;
      LG_HOLD: if (!req_i)                             st_d = LG_OFF;
      default:                                         st_d = LG_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LG_OFF;
    else        st_q <= st_d;
  end

  assign clr_o   = (st_d == LG_ON) != (st_q == LG_ON);
  assign drive_o = (st_q == LG_ON);

endmodule

// File: rtl/light_guard.sv
module light_guard #(
  parameter int unsigned TICK_DIV = 200000,
  parameter int unsigned LIM_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [LIM_W-1:0] on_limit_i,
  input  logic [LIM_W-1:0] off_limit_i,
  input  logic             on_chk_en_i,
  input  logic             off_chk_en_i,
  output logic             drive_o
);

  logic clr;
  logic tick;
  logic win_done;
  logic [LIM_W-1:0] act_limit;

  // The window serves the on-time while driving, the off-time otherwise.
  assign act_limit = drive_o ? on_limit_i : off_limit_i;

  lg_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .tick_o (tick)
  );

  lg_window #(.LIM_W(LIM_W)) win_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr),
    .tick_i  (tick),
    .limit_i (act_limit),
    .done_o  (win_done)
  );

  lg_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .on_en_i    (on_chk_en_i),
    .off_en_i   (off_chk_en_i),
    .win_done_i (win_done),
    .clr_o      (clr),
    .drive_o    (drive_o)
  );

endmodule

// File: rtl/light_guard_chk.sv
module lg_guard_chk #(
  parameter int unsigned TICK_DIV = 200000,
  parameter int unsigned LIM_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [LIM_W-1:0] on_limit_i,
  input  logic [LIM_W-1:0] off_limit_i,
  input  logic             on_chk_en_i,
  input  logic             off_chk_en_i,
  input  logic             drive_o
);

  logic [LIM_W-1:0] on_lim_q, off_lim_q;
  logic [31:0]      hi_run, lo_run;
  logic             clean;
  logic [LIM_W-1:0] on_eff, off_eff;
  logic [31:0]      on_bound, off_bound;

  assign on_eff    = (on_lim_q == '0)  ? {{(LIM_W-1){1'b0}}, 1'b1} : on_lim_q;
  assign off_eff   = (off_lim_q == '0) ? {{(LIM_W-1){1'b0}}, 1'b1} : off_lim_q;
  assign on_bound  = 32'(on_eff)  * 32'(TICK_DIV);
  assign off_bound = 32'(off_eff) * 32'(TICK_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_lim_q  <= '0;
      off_lim_q <= '0;
      hi_run    <= '0;
      lo_run    <= '0;
      clean     <= 1'b0;
    end else begin
      on_lim_q  <= on_limit_i;
      off_lim_q <= off_limit_i;
      if (drive_o && on_chk_en_i && (on_limit_i == on_lim_q)) hi_run <= hi_run + 1;
      else                                                    hi_run <= '0;
      if (drive_o) begin
        lo_run <= '0;
        clean  <= 1'b1;
      end else begin
        if (lo_run != '1) lo_run <= lo_run + 1;
        if (!off_chk_en_i || (off_limit_i != off_lim_q)) clean <= 1'b0;
      end
    end
  end

  // R3: a rising drive needs a request in the previous cycle
  a_r3_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_o) |-> $past(req_i));

  // R4: request released while driving -> drive off next cycle
  a_r4_fall_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drive_o) && !$past(req_i)) |-> !drive_o);

  // R5: high period bounded by the on-time limit
  a_r5_on_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_o && on_chk_en_i) |-> (hi_run < on_bound));

  // R7: low period before a turn-on at least the off-time limit
  a_r7_off_min: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drive_o) && clean) |-> (lo_run >= off_bound));

  logic unused_ok;
  assign unused_ok = req_i;

endmodule

bind light_guard lg_guard_chk #(.TICK_DIV(TICK_DIV), .LIM_W(LIM_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_i        (req_i),
  .on_limit_i   (on_limit_i),
  .off_limit_i  (off_limit_i),
  .on_chk_en_i  (on_chk_en_i),
  .off_chk_en_i (off_chk_en_i),
  .drive_o      (drive_o)
);

// File: tb/light_guard_tb_top.sv
`timescale 1ns/1ps
module light_guard_tb_top;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_i = 1'b0;
  logic [7:0] on_limit_i = '0;
  logic [7:0] off_limit_i = '0;
  logic       on_chk_en_i = 1'b0;
  logic       off_chk_en_i = 1'b0;
  logic       drive_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  light_guard #(.TICK_DIV(DIV), .LIM_W(8)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .on_limit_i   (on_limit_i),
    .off_limit_i  (off_limit_i),
    .on_chk_en_i  (on_chk_en_i),
    .off_chk_en_i (off_chk_en_i),
    .drive_o      (drive_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Counts consecutive negedge samples at the given level, starting now.
  task automatic run_len(input logic lvl, input int maxn, output int n);
    n = 0;
    while (drive_o == lvl && n < maxn) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic idle(input int k);
    req_i = 1'b0;
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    logic prev;
    logic [7:0] lfsr;

    // R1: reset state and first request right after reset
    repeat (3) @(negedge clk);
    chk(drive_o == 1'b0, "R1 reset low", int'(drive_o), 0);
    rst_n = 1'b1;
    off_chk_en_i = 1'b1;
    off_limit_i  = 8'd10;
    req_i = 1'b1;
    @(negedge clk);
    chk(drive_o == 1'b1, "R1 first request after reset", int'(drive_o), 1);
    req_i = 1'b0;
    @(negedge clk);
    chk(drive_o == 1'b0, "R4 fall after release", int'(drive_o), 0);
    off_chk_en_i = 1'b0;
    idle(60);

    // R2: pass-through with both guards off
    lfsr = 8'hA5;
    prev = 1'b0;
    for (int i = 0; i < 60; i++) begin
      chk(drive_o == prev, "R2 follow request", int'(drive_o), int'(prev));
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      req_i = lfsr[0];
      prev = lfsr[0];
      @(negedge clk);
    end
    idle(4);

    // R5, R6, R9: on-time cap sweep
    on_chk_en_i = 1'b1;
    off_chk_en_i = 1'b0;
    for (int L = 0; L <= 6; L++) begin
      on_limit_i = 8'(L);
      idle(3);
      req_i = 1'b1;
      @(negedge clk);
      chk(drive_o == 1'b1, "R3 turn-on latency", int'(drive_o), 1);
      run_len(1'b1, 2000, n);
      chk(n == eff(L) * DIV, (L == 0) ? "R9 zero on-limit" : "R5 on-time cap", n, eff(L) * DIV);
      run_len(1'b0, 20, n);
      chk(n == 20, "R6 held low while request stays", n, 20);
      idle(2);
      req_i = 1'b1;
      @(negedge clk);
      chk(drive_o == 1'b1, "R6 new request accepted", int'(drive_o), 1);
      req_i = 1'b0;
      @(negedge clk);
      chk(drive_o == 1'b0, "R4 fall after release", int'(drive_o), 0);
    end
    on_chk_en_i = 1'b0;

    // R7, R9: postponed turn-on sweep
    off_chk_en_i = 1'b1;
    for (int M = 0; M <= 6; M++) begin
      off_limit_i = 8'(M);
      idle(40);
      req_i = 1'b1;
      repeat (3) @(negedge clk);
      req_i = 1'b0;
      @(negedge clk);
      req_i = 1'b1;
      run_len(1'b0, 2000, n);
      chk(n == eff(M) * DIV, (M == 0) ? "R9 zero off-limit" : "R7 postponed turn-on", n, eff(M) * DIV);
    end

    // R8: early request dropped before the off-time ends
    off_limit_i = 8'd5;
    idle(40);
    req_i = 1'b1;
    repeat (3) @(negedge clk);
    req_i = 1'b0;
    @(negedge clk);
    req_i = 1'b1;
    repeat (2) @(negedge clk);
    req_i = 1'b0;
    run_len(1'b0, 40, n);
    chk(n == 40, "R8 cancelled early request", n, 40);
    req_i = 1'b1;
    @(negedge clk);
    chk(drive_o == 1'b1, "R8 later request accepted", int'(drive_o), 1);

    // R10: off-time counted from a cap-forced fall
    on_chk_en_i = 1'b1;
    on_limit_i  = 8'd2;
    off_limit_i = 8'd3;
    idle(40);
    req_i = 1'b1;
    @(negedge clk);
    run_len(1'b1, 2000, n);
    chk(n == 2 * DIV, "R10 cap before off-time", n, 2 * DIV);
    req_i = 1'b0;
    @(negedge clk);
    req_i = 1'b1;
    run_len(1'b0, 2000, n);
    chk(n + 1 == 3 * DIV, "R10 off-time from forced fall", n + 1, 3 * DIV);

    idle(4);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule